// File: doc/BRIEF.md
# FFT Ping-Pong Address Generator

This block produces, for every butterfly cycle of an in-place radix-2 FFT, the addresses that the surrounding datapath needs. The samples live in two read banks (a and b) and two write banks, and twiddle factors come from their own memory. The controller pulses `start_i` once before each stage, then raises `step_i` for each of the N/2 butterfly cycles of that stage, supplying the stage number, the half-stage flag, the odd-cycle flag and the write-ordering select. One clock after each step the block presents registered read, twiddle and write addresses together with the two bus-swap controls.

Read addresses walk linearly through the bank. The twiddle address advances by a stage-dependent stride and wraps within the half-size twiddle table. In the regular write ordering the two write banks are filled in an interleaved fashion, stepping by two, and the roles of the banks exchange halfway through the stage. In the final-stage ordering both write banks receive the same address, a counter bit-reversed over the bank address width; since consecutive results go to alternating banks, this gives the fully bit-reversed sample order. The addresses belong to the butterfly issued in that step; any datapath latency is added by the user.

Top module: `fft_pingpong_agen`

## Requirements
- R1: After reset `valid_o`, `in_swap_o` and `out_swap_o` are 0 and all address outputs are 0.
- R2: A cycle with `start_i` high clears all stage state; a `step_i` in that same cycle is discarded and produces no `valid_o`.
- R3: Each `step_i` yields `valid_o` high on the next cycle with `rd_a_addr_o` and `rd_b_addr_o` both equal to the step's index within the stage, counting 0, 1, 2, … from the last start.
- R4: For step index i in stage s (1 to LOG2N), `tw_addr_o` equals (i · (N >> s)) mod (N/2).
- R5: `in_swap_o` equals the `odd_i` value given with the step (1 means operand a is taken from bank b and operand b from bank a).
- R6: With `bitrev_i` = 0, for step index i and k = i mod (N/4): in the first half (`half_i` = 0) the write addresses are a = 2k, b = 2k+1; in the second half (`half_i` = 1) they are a = 2k+1, b = 2k.
- R7: `out_swap_o` is 1 exactly for steps with `bitrev_i` = 0 and `half_i` = 1 (1 means the b result goes to write bank a and the a result to write bank b).
- R8: With `bitrev_i` = 1 both write addresses equal step index i reversed bit for bit over LOG2N-1 bits, regardless of `half_i`.
- R9: A cycle without `step_i` advances no counter and gives `valid_o` = 0 on the next cycle.
- R10: Over one complete stage, in either ordering, every address of each write bank is produced exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Stage start pulse; clears counters |
| step_i | input | 1 | One butterfly cycle is issued |
| stage_i | input | $clog2(LOG2N+1) | Stage number, 1 to LOG2N |
| half_i | input | 1 | 1 during the second half of the stage |
| odd_i | input | 1 | 1 on odd butterfly cycles |
| bitrev_i | input | 1 | 0 regular interleaved writes, 1 bit-reversed writes; constant within a stage |
| valid_o | output | 1 | Addresses below belong to the step of the previous cycle |
| rd_a_addr_o | output | LOG2N-1 | Read address for bank a |
| rd_b_addr_o | output | LOG2N-1 | Read address for bank b |
| tw_addr_o | output | LOG2N-1 | Twiddle memory address |
| in_swap_o | output | 1 | Exchange the read operands between banks |
| wr_a_addr_o | output | LOG2N-1 | Write address for bank a |
| wr_b_addr_o | output | LOG2N-1 | Write address for bank b |
| out_swap_o | output | 1 | Exchange the results between write banks |

## Verification
The bench uses the default LOG2N = 4, a 16-point transform with eight-word banks and three-bit addresses, which is small enough that all four stages run in full. Those stages bring every twiddle stride within reach, including stage 1 whose stride of N/2 masks to zero, the half-point bank exchange in the regular stages, and the three-bit reversal in the last stage. A repeated stage with idle gaps and a start that collides with a step exercise the hold and discard behaviour.

// File: rtl/fft_ag_pkg.sv
package fft_ag_pkg;

    // Write ordering for one stage
    typedef enum logic {
        WR_INTERLEAVED = 1'b0,
        WR_BITREV      = 1'b1
    } wr_mode_e;

endpackage

// File: rtl/fft_ag_rd_ctr.sv
module fft_ag_rd_ctr #(
    parameter int LOG2N = 4,
    parameter int SW    = $clog2(LOG2N + 1),
    parameter int AW    = LOG2N - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          step_i,
    input  logic [SW-1:0] stage_i,
    output logic [AW-1:0] idx_o,
    output logic [AW-1:0] tw_o
);

    typedef struct packed {
        logic [AW-1:0] idx;
        logic [AW-1:0] tw;
    } rd_state_t;

    rd_state_t   st_d, st_q;
    logic [LOG2N:0] stride_full;

    always_comb begin
        stride_full = {1'b1, {LOG2N{1'b0}}} >> stage_i;
        st_d = st_q;
        if (start_i) begin
            st_d = '0;
        end else if (step_i) begin
            st_d.idx = st_q.idx + AW'(1);
            // masking to N/2-1 falls out of the AW-bit width
            st_d.tw  = st_q.tw + stride_full[AW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx_o = st_q.idx;
    assign tw_o  = st_q.tw;

endmodule

// File: rtl/fft_ag_wr_ctr.sv
module fft_ag_wr_ctr
    import fft_ag_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          step_i,
    input  logic          half_i,
    input  wr_mode_e      mode_i,
    output logic [AW-1:0] cur_a_o,
    output logic [AW-1:0] cur_b_o
);

    typedef struct packed {
        logic [AW-1:0] ptr_a;
        logic [AW-1:0] ptr_b;
        logic          half_seen;
    } wr_state_t;

    wr_state_t     st_d, st_q;
    logic [AW-1:0] inc;
    logic          reload;

    always_comb begin
        inc    = (mode_i == WR_BITREV) ? AW'(1) : AW'(2);
        // first step of the second half restarts with exchanged offsets
        reload = step_i && (mode_i == WR_INTERLEAVED) && half_i && !st_q.half_seen;
        cur_a_o = reload ? AW'(1) : st_q.ptr_a + inc;
        cur_b_o = reload ? AW'(0) : st_q.ptr_b + inc;

        st_d = st_q;
        if (start_i) begin
            // pointers sit one increment before their first address
            st_d.ptr_a     = AW'(0) - inc;
            st_d.ptr_b     = ((mode_i == WR_BITREV) ? AW'(0) : AW'(1)) - inc;
            st_d.half_seen = 1'b0;
        end else if (step_i) begin
            st_d.ptr_a = cur_a_o;
            st_d.ptr_b = cur_b_o;
            if (reload) st_d.half_seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/fft_ag_bitrev.sv
module fft_ag_bitrev #(
    parameter int W = 3
) (
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);

    for (genvar g = 0; g < W; g++) begin : g_rev
        assign out_o[g] = in_i[W-1-g];
    end

endmodule

// File: rtl/fft_pingpong_agen.sv
module fft_pingpong_agen
    import fft_ag_pkg::*;
#(
    parameter int LOG2N = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic                         step_i,
    input  logic [$clog2(LOG2N+1)-1:0]   stage_i,
    input  logic                         half_i,
    input  logic                         odd_i,
    input  logic                         bitrev_i,
    output logic                         valid_o,
    output logic [LOG2N-2:0]             rd_a_addr_o,
    output logic [LOG2N-2:0]             rd_b_addr_o,
    output logic [LOG2N-2:0]             tw_addr_o,
    output logic                         in_swap_o,
    output logic [LOG2N-2:0]             wr_a_addr_o,
    output logic [LOG2N-2:0]             wr_b_addr_o,
    output logic                         out_swap_o
);

    localparam int SW = $clog2(LOG2N + 1);
    localparam int AW = LOG2N - 1;

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] rd;
        logic [AW-1:0] tw;
        logic          iswap;
        logic [AW-1:0] wa;
        logic [AW-1:0] wb;
        logic          oswap;
    } out_t;

    out_t          o_d, o_q;
    wr_mode_e      mode;
    logic          step_eff;
    logic [AW-1:0] idx, tw, cur_a, cur_b, rev_a, rev_b;

    assign mode     = wr_mode_e'(bitrev_i);
    assign step_eff = step_i && !start_i;

    fft_ag_rd_ctr #(.LOG2N(LOG2N), .SW(SW), .AW(AW)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .step_i  (step_eff),
        .stage_i (stage_i),
        .idx_o   (idx),
        .tw_o    (tw)
    );

    fft_ag_wr_ctr #(.AW(AW)) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .step_i  (step_eff),
        .half_i  (half_i),
        .mode_i  (mode),
        .cur_a_o (cur_a),
        .cur_b_o (cur_b)
    );

    fft_ag_bitrev #(.W(AW)) u_rev_a (.in_i(cur_a), .out_o(rev_a));
    fft_ag_bitrev #(.W(AW)) u_rev_b (.in_i(cur_b), .out_o(rev_b));

    always_comb begin
        o_d       = o_q;
        o_d.valid = step_eff;
        if (step_eff) begin
            o_d.rd    = idx;
            o_d.tw    = tw;
            o_d.iswap = odd_i;
            o_d.wa    = (mode == WR_BITREV) ? rev_a : cur_a;
            o_d.wb    = (mode == WR_BITREV) ? rev_b : cur_b;
            o_d.oswap = (mode == WR_INTERLEAVED) && half_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign valid_o     = o_q.valid;
    assign rd_a_addr_o = o_q.rd;
    assign rd_b_addr_o = o_q.rd;
    assign tw_addr_o   = o_q.tw;
    assign in_swap_o   = o_q.iswap;
    assign wr_a_addr_o = o_q.wa;
    assign wr_b_addr_o = o_q.wb;
    assign out_swap_o  = o_q.oswap;

    // R3
    rd_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && step_i && !start_i) |=> (rd_a_addr_o == AW'($past(rd_a_addr_o) + AW'(1))));

    // R2
    start_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !valid_o);

    // R5
    in_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !start_i) |=> (in_swap_o == $past(odd_i)));

    // R8
    bitrev_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !start_i && bitrev_i) |=> (wr_a_addr_o == wr_b_addr_o && !out_swap_o));

    // R6
    parity_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !start_i && !bitrev_i) |=> (wr_a_addr_o[0] != wr_b_addr_o[0]));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> (!valid_o && $stable(tw_addr_o) && $stable(wr_a_addr_o)));

endmodule

// File: tb/fft_pingpong_agen_tb.sv
module fft_pingpong_agen_tb;

    localparam int LOG2N = 4;
    localparam int N     = 1 << LOG2N;
    localparam int NB    = N / 2;
    localparam int AW    = LOG2N - 1;
    localparam int SW    = $clog2(LOG2N + 1);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] tw;
        logic [AW-1:0] wa;
        logic [AW-1:0] wb;
        logic          isw;
        logic          osw;
        logic          br;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0, step_i = 1'b0, half_i = 1'b0, odd_i = 1'b0, bitrev_i = 1'b0;
    logic [SW-1:0] stage_i = '0;
    logic          valid_o, in_swap_o, out_swap_o;
    logic [AW-1:0] rd_a_addr_o, rd_b_addr_o, tw_addr_o, wr_a_addr_o, wr_b_addr_o;

    int   errors = 0;
    int   checks = 0;
    exp_t q[$];
    int   cnt_a[NB];
    int   cnt_b[NB];

    always #2.5 clk = ~clk;

    fft_pingpong_agen #(.LOG2N(LOG2N)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .step_i(step_i),
        .stage_i(stage_i), .half_i(half_i), .odd_i(odd_i), .bitrev_i(bitrev_i),
        .valid_o(valid_o), .rd_a_addr_o(rd_a_addr_o), .rd_b_addr_o(rd_b_addr_o),
        .tw_addr_o(tw_addr_o), .in_swap_o(in_swap_o), .wr_a_addr_o(wr_a_addr_o),
        .wr_b_addr_o(wr_b_addr_o), .out_swap_o(out_swap_o)
    );

    function automatic logic [AW-1:0] rev(input int v);
        logic [AW-1:0] r;
        for (int b = 0; b < AW; b++) r[b] = v[AW-1-b];
        return r;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: one butterfly step with its expected result
    task automatic drive_step(input int stage, input int i, input bit br);
        exp_t e;
        int   k;
        bit   h;
        @(negedge clk);
        h = (i >= NB / 2);
        k = i % (NB / 2);
        start_i = 1'b0; step_i = 1'b1; half_i = h; odd_i = i[0];
        e.rd  = AW'(i);
        e.tw  = AW'((i * (N >> stage)) % (N / 2));
        e.isw = i[0];
        e.br  = br;
        if (br) begin
            e.wa = rev(i); e.wb = rev(i); e.osw = 1'b0;
        end else begin
            e.wa = AW'(2 * k + (h ? 1 : 0));
            e.wb = AW'(2 * k + (h ? 0 : 1));
            e.osw = h;
        end
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            start_i = 1'b0; step_i = 1'b0;
        end
    endtask

    task automatic run_stage(input int stage, input bit br, input bit gaps, input bit collide);
        @(negedge clk);
        stage_i = SW'(stage); bitrev_i = br; start_i = 1'b1;
        step_i = collide;   // R2: a step coinciding with start is dropped
        for (int i = 0; i < NB; i++) begin
            drive_step(stage, i, br);
            if (gaps && (i % 3 == 1)) idle(1 + i % 2);
        end
        idle(3);
        for (int j = 0; j < NB; j++) begin
            chk("R10 bank a writes", cnt_a[j], 1);
            chk("R10 bank b writes", cnt_b[j], 1);
            cnt_a[j] = 0;
            cnt_b[j] = 0;
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && valid_o) begin
                if (q.size() == 0) begin
                    chk("R2 R9 unexpected valid", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk("R3 rd a", rd_a_addr_o, e.rd);
                    chk("R3 rd b", rd_b_addr_o, e.rd);
                    chk("R4 tw", tw_addr_o, e.tw);
                    chk("R5 in swap", in_swap_o, e.isw);
                    chk(e.br ? "R8 wr a" : "R6 wr a", wr_a_addr_o, e.wa);
                    chk(e.br ? "R8 wr b" : "R6 wr b", wr_b_addr_o, e.wb);
                    chk("R7 out swap", out_swap_o, e.osw);
                    cnt_a[wr_a_addr_o]++;
                    cnt_b[wr_b_addr_o]++;
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int j = 0; j < NB; j++) begin
            cnt_a[j] = 0;
            cnt_b[j] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 valid", valid_o, 0);
        chk("R1 rd", rd_a_addr_o, 0);
        chk("R1 tw", tw_addr_o, 0);
        chk("R1 wr a", wr_a_addr_o, 0);
        chk("R1 wr b", wr_b_addr_o, 0);
        chk("R1 swaps", {in_swap_o, out_swap_o}, 0);

        for (int s = 1; s < LOG2N; s++) run_stage(s, 1'b0, 1'b0, 1'b0);
        run_stage(LOG2N, 1'b1, 1'b0, 1'b0);
        // R9 idle gaps, R2 start/step collision
        run_stage(2, 1'b0, 1'b1, 1'b1);
        run_stage(LOG2N, 1'b1, 1'b1, 1'b1);
        run_stage(3, 1'b0, 1'b0, 1'b1);

        chk("R9 queue drained", q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule